// File: doc/BRIEF.md
# Endpoint Interrupt Status Aggregator

This block keeps the interrupt status of every endpoint of a USB device controller. Each endpoint number has one status register for its IN direction and one for its OUT direction. The protocol engine reports events as single-cycle pulses, each tagged with a kind, an endpoint number and a direction. The block turns these pulses into sticky status bits. Some bits come straight from an event. Others are derived inside the block:

- the IN token mismatch check against the endpoint at the head of the transmit FIFO;
- the NAK-effective flag for periodic IN endpoints;
- a per-endpoint counter that flags SETUP packets arriving back to back on a control endpoint.

Software reads and clears the status bits over a simple register bus, with combinational reads and write-one-to-clear writes. An all-endpoints summary word is the OR of each endpoint's unmasked bits. Two interrupt outputs are the OR of the summary halves. Because the summary and the outputs are derived and never stored, clearing an endpoint bit clears them too.

Top module: `ep_irq_aggregator`

## Requirements
- R1: After reset, every endpoint register and the summary read 0, the interrupt outputs are low, and the mask register (address 0x01C) reads 0x0007_000F.
- R2: `ev_kind` codes are 0 transfer done, 1 timeout, 2 IN token, 3 OUT token and 4 SETUP. A transfer-done event sets bit 0 of the register of `ev_ep`, in the direction given by `ev_dir_in`, one cycle after the event.
- R3: Writing to an endpoint register clears exactly the status bits written as 1. Bits above the status field read as 0. IN registers hold 4 bits and OUT registers hold 3 bits.
- R4: When an event sets a bit in the same cycle as a write that clears it, the bit ends up set.
- R5: An IN token on a periodic endpoint sets IN bit 2 on the token's endpoint when `fifo_head_ep` differs from that endpoint. It sets nothing when they match or when the endpoint is not periodic.
- R6: An IN token on a periodic endpoint whose `ep_nak_req` is high sets IN bit 3 (NAK effective). A high `ep_stall` on that endpoint blocks it, because STALL takes priority over NAK.
- R7: A one-cycle `ep_cnak` pulse clears IN bit 3 of that endpoint.
- R8: A SETUP event sets OUT bit 1. The fourth and any later consecutive SETUP on an endpoint with `ep_ctrl` high also sets OUT bit 2. On a non-control endpoint, OUT bit 2 is never set.
- R9: Any IN token or OUT token on an endpoint number restarts that endpoint's back-to-back SETUP count from zero.
- R10: Summary bit n (address 0x018) is the OR of the IN status of endpoint n masked by mask bits 3:0. Summary bit 16+n is the same for OUT status, masked by mask bits 18:16. `irq_in_any` and `irq_out_any` are the OR of the low and high summary halves. Masking never changes the stored status.
- R11: IN registers sit at 0x100 + n*0x20 and OUT registers at 0x300 + n*0x20. Any other address reads 0, and a write to it clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event pulse valid |
| ev_kind | input | 3 | Event kind code |
| ev_dir_in | input | 1 | Transfer-done direction: 1 IN, 0 OUT |
| ev_ep | input | 4 | Endpoint number of the event |
| fifo_head_ep | input | 4 | Endpoint owning the data at the transmit FIFO head |
| ep_periodic | input | 16 | Per-endpoint periodic IN configuration |
| ep_ctrl | input | 16 | Per-endpoint control-endpoint configuration |
| ep_nak_req | input | 16 | Per-endpoint NAK requested by software |
| ep_stall | input | 16 | Per-endpoint STALL requested by software |
| ep_cnak | input | 16 | Per-endpoint clear-NAK pulse |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| ep_summary | output | 32 | All-endpoints summary |
| irq_in_any | output | 1 | Any unmasked IN endpoint status |
| irq_out_any | output | 1 | Any unmasked OUT endpoint status |

## Verification
Events, clear-NAK pulses and bus writes are captured on a rising edge. Their effect on the endpoint registers, the summary and both interrupt outputs is therefore due in the cycle that follows. Reads are combinational and are valid in the same cycle as the address. The bench drives every stimulus at a falling edge and holds it over one rising edge. It then sets the read address at a later falling edge and samples 1 ns after it, so each result is taken exactly one register stage after its cause. Sweeps cover all 16 endpoints in both directions. SETUP sequences of one to five packets check the fourth-packet threshold.

// File: rtl/ep_irq_pkg.sv
`timescale 1ns/1ps
package ep_irq_pkg;

  typedef enum logic [2:0] {
    EV_XFER_DONE = 3'd0,
    EV_TIMEOUT   = 3'd1,
    EV_IN_TOKEN  = 3'd2,
    EV_OUT_TOKEN = 3'd3,
    EV_SETUP     = 3'd4
  } ev_kind_e;

  localparam int IN_W  = 4;
  localparam int OUT_W = 3;

  localparam int IN_DONE     = 0;
  localparam int IN_TIMEOUT  = 1;
  localparam int IN_MISMATCH = 2;
  localparam int IN_NAK_EFF  = 3;

  localparam int OUT_DONE  = 0;
  localparam int OUT_SETUP = 1;
  localparam int OUT_B2B   = 2;

  localparam int SUM_OUT_LSB = 16;

  localparam int                     SETUP_CNT_W   = 2;
  localparam logic [SETUP_CNT_W-1:0] SETUP_CNT_MAX = 2'd3;

  // Saturating count of SETUP packets since the last other token.
  function automatic logic [SETUP_CNT_W-1:0] setup_cnt_next(
    input logic [SETUP_CNT_W-1:0] cnt,
    input logic                   setup_hit,
    input logic                   other_tok
  );
    if (other_tok)                              return '0;
    else if (setup_hit && cnt != SETUP_CNT_MAX) return cnt + 1'b1;
    else                                        return cnt;
  endfunction

  // A SETUP that arrives once the count is already saturated is the 4th+.
  function automatic logic b2b_trigger(
    input logic [SETUP_CNT_W-1:0] cnt,
    input logic                   setup_hit
  );
    return setup_hit && (cnt == SETUP_CNT_MAX);
  endfunction

  // Sticky status update: set has priority over clear.
  function automatic logic [7:0] w1c_next(
    input logic [7:0] cur,
    input logic [7:0] set,
    input logic [7:0] clr
  );
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/ep_irq_in_slot.sv
`timescale 1ns/1ps
module ep_irq_in_slot import ep_irq_pkg::*; #(
  parameter int EP_W   = 4,
  parameter int EP_IDX = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_valid,
  input  ev_kind_e        ev_kind,
  input  logic            ev_dir_in,
  input  logic [EP_W-1:0] ev_ep,
  input  logic [EP_W-1:0] fifo_head_ep,
  input  logic            periodic,
  input  logic            nak_req,
  input  logic            stall,
  input  logic            cnak,
  input  logic            clr_wr,
  input  logic [IN_W-1:0] clr_data,
  output logic [IN_W-1:0] status
);

  localparam logic [EP_W-1:0] MY_EP = EP_W'(EP_IDX);

  logic            ev_hit;
  logic            in_tok;
  logic            set_done;
  logic            set_timeout;
  logic            set_mismatch;
  logic            set_nak;
  logic [IN_W-1:0] set_vec;
  logic [IN_W-1:0] clr_vec;

  assign ev_hit       = ev_valid && (ev_ep == MY_EP);
  assign in_tok       = ev_hit && (ev_kind == EV_IN_TOKEN);
  assign set_done     = ev_hit && (ev_kind == EV_XFER_DONE) && ev_dir_in;
  assign set_timeout  = ev_hit && (ev_kind == EV_TIMEOUT);
  assign set_mismatch = in_tok && periodic && (fifo_head_ep != MY_EP);
  assign set_nak      = in_tok && periodic && nak_req && !stall;

  always_comb begin
    set_vec              = '0;
    set_vec[IN_DONE]     = set_done;
    set_vec[IN_TIMEOUT]  = set_timeout;
    set_vec[IN_MISMATCH] = set_mismatch;
    set_vec[IN_NAK_EFF]  = set_nak;
  end

  assign clr_vec = (clr_wr ? clr_data : '0) | (cnak ? IN_W'(1 << IN_NAK_EFF) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= IN_W'(w1c_next(8'(status), 8'(set_vec), 8'(clr_vec)));
  end

  // R4: every bit that an event sets is present in the next cycle
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));

  // R7: clear-NAK removes NAK-effective unless a new set arrives
  a_r7_cnak_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cnak && !set_nak) |=> !status[IN_NAK_EFF]);

  // R6: NAK-effective only rises after an IN token with NAK and no STALL
  a_r6_stall_blocks_nak: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[IN_NAK_EFF]) |-> $past(in_tok && periodic && nak_req && !stall));

endmodule

// File: rtl/ep_irq_out_slot.sv
`timescale 1ns/1ps
module ep_irq_out_slot import ep_irq_pkg::*; #(
  parameter int EP_W   = 4,
  parameter int EP_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  ev_kind_e         ev_kind,
  input  logic             ev_dir_in,
  input  logic [EP_W-1:0]  ev_ep,
  input  logic             is_ctrl,
  input  logic             clr_wr,
  input  logic [OUT_W-1:0] clr_data,
  output logic [OUT_W-1:0] status
);

  localparam logic [EP_W-1:0] MY_EP = EP_W'(EP_IDX);

  logic                   ev_hit;
  logic                   setup_hit;
  logic                   other_tok;
  logic                   set_done;
  logic                   set_b2b;
  logic [SETUP_CNT_W-1:0] setup_cnt;
  logic [OUT_W-1:0]       set_vec;
  logic [OUT_W-1:0]       clr_vec;

  assign ev_hit    = ev_valid && (ev_ep == MY_EP);
  assign setup_hit = ev_hit && (ev_kind == EV_SETUP);
  assign other_tok = ev_hit && ((ev_kind == EV_IN_TOKEN) || (ev_kind == EV_OUT_TOKEN));
  assign set_done  = ev_hit && (ev_kind == EV_XFER_DONE) && !ev_dir_in;
  assign set_b2b   = is_ctrl && b2b_trigger(setup_cnt, setup_hit);

  always_comb begin
    set_vec            = '0;
    set_vec[OUT_DONE]  = set_done;
    set_vec[OUT_SETUP] = setup_hit;
    set_vec[OUT_B2B]   = set_b2b;
  end

  assign clr_vec = clr_wr ? clr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_cnt <= '0;
      status    <= '0;
    end else begin
      setup_cnt <= setup_cnt_next(setup_cnt, setup_hit, other_tok);
      status    <= OUT_W'(w1c_next(8'(status), 8'(set_vec), 8'(clr_vec)));
    end
  end

  // R4: set beats a simultaneous clear
  a_r4_out_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));

  // R9: any other token restarts the SETUP count
  a_r9_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    other_tok |=> (setup_cnt == '0));

  // R8: back-to-back flag rises only on a saturated SETUP of a control endpoint
  a_r8_b2b_on_fourth: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[OUT_B2B]) |-> $past(setup_hit && is_ctrl && (setup_cnt == SETUP_CNT_MAX)));

endmodule

// File: rtl/ep_irq_regif.sv
`timescale 1ns/1ps
module ep_irq_regif import ep_irq_pkg::*; #(
  parameter int                NUM_EP    = 16,
  parameter int                EP_W      = 4,
  parameter int                ADDR_W    = 12,
  parameter int                STRIDE_LG = 5,
  parameter logic [ADDR_W-1:0] IN_BASE   = 'h100,
  parameter logic [ADDR_W-1:0] OUT_BASE  = 'h300,
  parameter logic [ADDR_W-1:0] SUM_ADDR  = 'h018,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 'h01C
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic [31:0]             bus_wdata,
  input  logic [NUM_EP*IN_W-1:0]  in_status,
  input  logic [NUM_EP*OUT_W-1:0] out_status,
  output logic [NUM_EP-1:0]       in_clr_wr,
  output logic [NUM_EP-1:0]       out_clr_wr,
  output logic [31:0]             bus_rdata,
  output logic [31:0]             ep_summary
);

  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_EP << STRIDE_LG);

  logic [ADDR_W-1:0] off_in;
  logic [ADDR_W-1:0] off_out;
  logic              hit_in;
  logic              hit_out;
  logic              hit_sum;
  logic              hit_mask;
  logic [EP_W-1:0]   slot_in;
  logic [EP_W-1:0]   slot_out;
  logic [IN_W-1:0]   in_mask;
  logic [OUT_W-1:0]  out_mask;
  logic              unused_wdata;

  assign unused_wdata = ^{bus_wdata[31:SUM_OUT_LSB+OUT_W], bus_wdata[SUM_OUT_LSB-1:IN_W]};

  assign off_in   = bus_addr - IN_BASE;
  assign off_out  = bus_addr - OUT_BASE;
  assign hit_in   = (bus_addr >= IN_BASE) && (off_in < SPAN) && (off_in[STRIDE_LG-1:0] == '0);
  assign hit_out  = (bus_addr >= OUT_BASE) && (off_out < SPAN) && (off_out[STRIDE_LG-1:0] == '0);
  assign hit_sum  = (bus_addr == SUM_ADDR);
  assign hit_mask = (bus_addr == MASK_ADDR);
  assign slot_in  = off_in[STRIDE_LG +: EP_W];
  assign slot_out = off_out[STRIDE_LG +: EP_W];

  always_comb begin
    for (int i = 0; i < NUM_EP; i++) begin
      in_clr_wr[i]  = bus_wr && hit_in  && (int'(slot_in)  == i);
      out_clr_wr[i] = bus_wr && hit_out && (int'(slot_out) == i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_mask  <= '1;
      out_mask <= '1;
    end else if (bus_wr && hit_mask) begin
      in_mask  <= bus_wdata[IN_W-1:0];
      out_mask <= bus_wdata[SUM_OUT_LSB +: OUT_W];
    end
  end

  for (genvar g = 0; g < SUM_OUT_LSB; g++) begin : g_sum
    if (g < NUM_EP) begin : g_live
      assign ep_summary[g]             = |(in_status[g*IN_W +: IN_W] & in_mask);
      assign ep_summary[SUM_OUT_LSB+g] = |(out_status[g*OUT_W +: OUT_W] & out_mask);
    end else begin : g_none
      assign ep_summary[g]             = 1'b0;
      assign ep_summary[SUM_OUT_LSB+g] = 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_in)
      bus_rdata[IN_W-1:0] = in_status[int'(slot_in)*IN_W +: IN_W];
    else if (hit_out)
      bus_rdata[OUT_W-1:0] = out_status[int'(slot_out)*OUT_W +: OUT_W];
    else if (hit_sum)
      bus_rdata = ep_summary;
    else if (hit_mask) begin
      bus_rdata[IN_W-1:0]              = in_mask;
      bus_rdata[SUM_OUT_LSB +: OUT_W]  = out_mask;
    end
  end

  // R11: the decoded regions never overlap
  a_r11_one_region: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_in, hit_out, hit_sum, hit_mask}));

  // R11: at most one endpoint register is cleared per write
  a_r11_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({in_clr_wr, out_clr_wr}) <= 1);

endmodule

// File: rtl/ep_irq_aggregator.sv
`timescale 1ns/1ps
module ep_irq_aggregator import ep_irq_pkg::*; #(
  parameter int                NUM_EP    = 16,
  parameter int                ADDR_W    = 12,
  parameter int                STRIDE_LG = 5,
  parameter logic [ADDR_W-1:0] IN_BASE   = 'h100,
  parameter logic [ADDR_W-1:0] OUT_BASE  = 'h300,
  parameter logic [ADDR_W-1:0] SUM_ADDR  = 'h018,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 'h01C,
  localparam int               EP_W      = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [2:0]        ev_kind,
  input  logic              ev_dir_in,
  input  logic [EP_W-1:0]   ev_ep,
  input  logic [EP_W-1:0]   fifo_head_ep,
  input  logic [NUM_EP-1:0] ep_periodic,
  input  logic [NUM_EP-1:0] ep_ctrl,
  input  logic [NUM_EP-1:0] ep_nak_req,
  input  logic [NUM_EP-1:0] ep_stall,
  input  logic [NUM_EP-1:0] ep_cnak,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [31:0]       ep_summary,
  output logic              irq_in_any,
  output logic              irq_out_any
);

  ev_kind_e                 kind_e;
  logic [NUM_EP*IN_W-1:0]   in_status;
  logic [NUM_EP*OUT_W-1:0]  out_status;
  logic [NUM_EP-1:0]        in_clr_wr;
  logic [NUM_EP-1:0]        out_clr_wr;

  assign kind_e = ev_kind_e'(ev_kind);

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    ep_irq_in_slot #(.EP_W(EP_W), .EP_IDX(e)) u_in (
      .clk          (clk),
      .rst_n        (rst_n),
      .ev_valid     (ev_valid),
      .ev_kind      (kind_e),
      .ev_dir_in    (ev_dir_in),
      .ev_ep        (ev_ep),
      .fifo_head_ep (fifo_head_ep),
      .periodic     (ep_periodic[e]),
      .nak_req      (ep_nak_req[e]),
      .stall        (ep_stall[e]),
      .cnak         (ep_cnak[e]),
      .clr_wr       (in_clr_wr[e]),
      .clr_data     (bus_wdata[IN_W-1:0]),
      .status       (in_status[e*IN_W +: IN_W])
    );

    ep_irq_out_slot #(.EP_W(EP_W), .EP_IDX(e)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_valid  (ev_valid),
      .ev_kind   (kind_e),
      .ev_dir_in (ev_dir_in),
      .ev_ep     (ev_ep),
      .is_ctrl   (ep_ctrl[e]),
      .clr_wr    (out_clr_wr[e]),
      .clr_data  (bus_wdata[OUT_W-1:0]),
      .status    (out_status[e*OUT_W +: OUT_W])
    );
  end

  ep_irq_regif #(
    .NUM_EP    (NUM_EP),
    .EP_W      (EP_W),
    .ADDR_W    (ADDR_W),
    .STRIDE_LG (STRIDE_LG),
    .IN_BASE   (IN_BASE),
    .OUT_BASE  (OUT_BASE),
    .SUM_ADDR  (SUM_ADDR),
    .MASK_ADDR (MASK_ADDR)
  ) u_regif (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .in_status  (in_status),
    .out_status (out_status),
    .in_clr_wr  (in_clr_wr),
    .out_clr_wr (out_clr_wr),
    .bus_rdata  (bus_rdata),
    .ep_summary (ep_summary)
  );

  assign irq_in_any  = |ep_summary[SUM_OUT_LSB-1:0];
  assign irq_out_any = |ep_summary[31:SUM_OUT_LSB];

  // R10: an interrupt output never stays high once every status bit is zero
  a_r10_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_in_any || irq_out_any) |-> ((|in_status) || (|out_status)));

endmodule

// File: tb/tb_ep_irq_aggregator.sv
`timescale 1ns/1ps
module tb_ep_irq_aggregator;

  localparam int          CLK_PERIOD = 10;
  localparam int          NEP        = 16;
  localparam logic [11:0] IN_B       = 12'h100;
  localparam logic [11:0] OUT_B      = 12'h300;
  localparam logic [11:0] SUM_A      = 12'h018;
  localparam logic [11:0] MASK_A     = 12'h01C;
  localparam logic [2:0]  K_DONE = 3'd0, K_TMO = 3'd1, K_INTK = 3'd2, K_OUTTK = 3'd3, K_SETUP = 3'd4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ev_valid = 1'b0;
  logic [2:0]      ev_kind = '0;
  logic            ev_dir_in = 1'b0;
  logic [3:0]      ev_ep = '0;
  logic [3:0]      fifo_head_ep = '0;
  logic [NEP-1:0]  ep_periodic = '1;
  logic [NEP-1:0]  ep_ctrl = '0;
  logic [NEP-1:0]  ep_nak_req = '0;
  logic [NEP-1:0]  ep_stall = '0;
  logic [NEP-1:0]  ep_cnak = '0;
  logic [11:0]     bus_addr = '0;
  logic            bus_wr = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [31:0]     ep_summary;
  logic            irq_in_any;
  logic            irq_out_any;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_irq_aggregator dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_dir_in(ev_dir_in), .ev_ep(ev_ep), .fifo_head_ep(fifo_head_ep),
    .ep_periodic(ep_periodic), .ep_ctrl(ep_ctrl), .ep_nak_req(ep_nak_req),
    .ep_stall(ep_stall), .ep_cnak(ep_cnak), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ep_summary(ep_summary),
    .irq_in_any(irq_in_any), .irq_out_any(irq_out_any)
  );

  function automatic logic [11:0] in_a(input int ep);
    return IN_B + 12'(ep * 32);
  endfunction

  function automatic logic [11:0] out_a(input int ep);
    return OUT_B + 12'(ep * 32);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fire(input logic [2:0] k, input logic din, input int ep, input int head);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_dir_in = din; ev_ep = 4'(ep); fifo_head_ep = 4'(head);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic setups(input int ep, input int count);
    for (int i = 0; i < count; i++) fire(K_SETUP, 1'b0, ep, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rchk("R1 summary", SUM_A, 32'h0);
    rchk("R1 mask", MASK_A, 32'h0007_000F);
    check("R1 irq", {30'b0, irq_in_any, irq_out_any}, 32'h0);
    for (int e = 0; e < NEP; e++) begin
      rchk("R1 in reg", in_a(e), 32'h0);
      rchk("R1 out reg", out_a(e), 32'h0);
    end

    // R2 / R10: transfer done on every endpoint, both directions
    for (int e = 0; e < NEP; e++) begin
      for (int d = 0; d < 2; d++) begin
        fire(K_DONE, d[0], e, 0);
        rchk("R2 done bit", d[0] ? in_a(e) : out_a(e), 32'h1);
        rchk("R2 other dir clean", d[0] ? out_a(e) : in_a(e), 32'h0);
        rchk("R10 summary bit", SUM_A, 32'h1 << (d[0] ? e : e + 16));
        check("R10 irq lines", {30'b0, irq_in_any, irq_out_any}, d[0] ? 32'h2 : 32'h1);
        wr(d[0] ? in_a(e) : out_a(e), 32'hFFFF_FFFF);
        rchk("R3 cleared", d[0] ? in_a(e) : out_a(e), 32'h0);
        rchk("R10 summary cleared", SUM_A, 32'h0);
      end
    end

    // R3: selective write-one-to-clear
    fire(K_DONE, 1'b1, 5, 0);
    fire(K_TMO, 1'b1, 5, 0);
    rchk("R3 two bits", in_a(5), 32'h3);
    wr(in_a(5), 32'h0000_0002);
    rchk("R3 only timeout cleared", in_a(5), 32'h1);
    wr(in_a(5), 32'h0);
    rchk("R3 zero write keeps", in_a(5), 32'h1);
    wr(in_a(5), 32'hFFFF_FFFF);
    rchk("R3 all cleared", in_a(5), 32'h0);

    // R4: set and clear in the same cycle
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = K_DONE; ev_dir_in = 1'b0; ev_ep = 4'd9;
    bus_addr = out_a(9); bus_wdata = 32'h1; bus_wr = 1'b1;
    @(negedge clk);
    ev_valid = 1'b0; bus_wr = 1'b0;
    rchk("R4 set wins", out_a(9), 32'h1);
    wr(out_a(9), 32'h1);
    rchk("R4 later clear", out_a(9), 32'h0);

    // R5: IN token mismatch sweep
    for (int e = 0; e < NEP; e++) begin
      fire(K_INTK, 1'b1, e, (e + 1) % NEP);
      rchk("R5 mismatch", in_a(e), 32'h4);
      wr(in_a(e), 32'hF);
      fire(K_INTK, 1'b1, e, e);
      rchk("R5 match no flag", in_a(e), 32'h0);
    end
    ep_periodic[3] = 1'b0;
    fire(K_INTK, 1'b1, 3, 9);
    rchk("R5 non-periodic ignored", in_a(3), 32'h0);

    // R6: NAK effective, STALL priority
    ep_nak_req[2] = 1'b1;
    fire(K_INTK, 1'b1, 2, 2);
    rchk("R6 nak effective", in_a(2), 32'h8);
    ep_nak_req[7] = 1'b1; ep_stall[7] = 1'b1;
    fire(K_INTK, 1'b1, 7, 7);
    rchk("R6 stall blocks", in_a(7), 32'h0);
    ep_nak_req[3] = 1'b1;
    fire(K_INTK, 1'b1, 3, 3);
    rchk("R6 non-periodic no nak", in_a(3), 32'h0);

    // R7: clear-NAK pulse
    ep_nak_req[2] = 1'b0;
    @(negedge clk); ep_cnak[2] = 1'b1;
    @(negedge clk); ep_cnak[2] = 1'b0;
    rchk("R7 cnak clears", in_a(2), 32'h0);

    // R8: back-to-back SETUP threshold
    ep_ctrl[1] = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      fire(K_SETUP, 1'b0, 1, 0);
      rchk("R8 setup count", out_a(1), (k >= 4) ? 32'h6 : 32'h2);
    end
    setups(6, 5);
    rchk("R8 non-control never b2b", out_a(6), 32'h2);
    wr(out_a(6), 32'h7);

    // R9: other tokens restart the count
    wr(out_a(1), 32'h7);
    fire(K_OUTTK, 1'b0, 1, 0);
    setups(1, 3);
    fire(K_OUTTK, 1'b0, 1, 0);
    setups(1, 3);
    rchk("R9 out token restarts", out_a(1), 32'h2);
    fire(K_INTK, 1'b1, 1, 1);
    setups(1, 3);
    rchk("R9 in token restarts", out_a(1), 32'h2);
    fire(K_SETUP, 1'b0, 1, 0);
    rchk("R9 fourth after restart", out_a(1), 32'h6);
    wr(out_a(1), 32'h7);

    // R10: masking
    wr(MASK_A, 32'h0007_0000);
    fire(K_DONE, 1'b1, 4, 0);
    rchk("R10 masked summary", SUM_A, 32'h0);
    check("R10 masked irq", {31'b0, irq_in_any}, 32'h0);
    rchk("R10 status kept", in_a(4), 32'h1);
    wr(MASK_A, 32'h0007_000F);
    rchk("R10 unmasked summary", SUM_A, 32'h0000_0010);
    check("R10 unmasked irq", {31'b0, irq_in_any}, 32'h1);
    wr(in_a(4), 32'h1);
    wr(MASK_A, 32'h0000_000F);
    fire(K_DONE, 1'b0, 9, 0);
    rchk("R10 out masked", SUM_A, 32'h0);
    wr(MASK_A, 32'h0007_000F);
    rchk("R10 out unmasked", SUM_A, 32'h0200_0000);
    wr(out_a(9), 32'h1);

    // R11: address map holes
    fire(K_DONE, 1'b1, 0, 0);
    wr(IN_B + 12'h004, 32'hFFFF_FFFF);
    rchk("R11 off-stride write ignored", in_a(0), 32'h1);
    rchk("R11 off-stride read zero", IN_B + 12'h004, 32'h0);
    rchk("R11 below base zero", IN_B - 12'h020, 32'h0);
    rchk("R11 past out range zero", OUT_B + 12'h200, 32'h0);
    wr(in_a(0), 32'h1);
    rchk("R11 final summary", SUM_A, 32'h0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule